// File: doc/BRIEF.md
# Decimal Counter Text Line Streamer

This block keeps a binary event counter and sends every value it takes to a host as a line of decimal text. Each line is a fixed number of zero-padded ASCII digits followed by a newline byte. The bytes go out one at a time through a byte-wide FIFO interface that the block only writes to. The FIFO offers an active-low "room available" flag, and the block pulses a write strobe for each byte. The counter moves on by one each time a full line has been sent. Eight LEDs show the top bits of the count.

The decimal form of the count is not computed when a line starts. A BCD counter with one digit per decimal place steps in lock with the binary counter and carries from digit to digit. When a line starts, its digits are copied into a holding shift register, so the value cannot change while the line is being sent. A small function turns each digit into its ASCII code. The default configuration is a 32-bit count with ten digits, which covers 4294967295. Narrower configurations use the same structure.

Top module: `dec_line_streamer`

## Requirements
- R1: While reset is high and in the first cycle after it, the write strobe is low, the read strobe is high and the LEDs are zero. The first line sent carries the value 0.
- R2: A line is DIGITS+1 bytes long. The digits come most significant first, zero-padded, and each is coded as 0x30 plus its value. The last byte is a newline, 0x0A.
- R3: Each completed line advances the binary count by one, so consecutive lines carry consecutive values.
- R4: The write strobe rises only after a cycle in which room_n was low. While room_n is high the block waits, and no byte is skipped or repeated.
- R5: The write strobe is high for exactly one cycle per byte. The FIFO takes the byte on the strobe's falling edge. The data bus holds the same value during the high cycle and at the fall.
- R6: The read strobe output is always high.
- R7: The LEDs equal the upper LED_W bits of the binary count. They change only in the second cycle after the strobe fall of a line's last byte.
- R8: When the count wraps from all ones to zero, every BCD digit is cleared, and the next line reads all zeros.
- R9: A digit that steps past 9 returns to 0 and carries into the next more significant digit. Several carries in a row take effect within the same step (for example 99 to 100).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| room_n | input | 1 | Low when the FIFO can accept a byte |
| wr_stb | output | 1 | Write strobe; the byte is taken on its falling edge |
| rd_stb_n | output | 1 | Read strobe, held inactive high |
| fifo_data | output | 8 | Byte to be written |
| leds | output | LED_W | Upper LED_W bits of the binary count |

## Verification
A small configuration (8-bit count, three digits) is swept over every count value and on past the wrap, so every carry chain and the clearing at wrap are exercised. The full-width default configuration runs its first lines with room_n held low, which shows the handshake at its fastest. It then runs past 99 to 100 with a pseudo-random room_n. That pattern stalls the block at arbitrary byte positions, so a skipped, repeated or early byte shows up as a wrong character in the expected text. Each captured byte is compared with digits worked out by division of the line number, and the LEDs are compared with the shifted line count after every line.

// File: rtl/dls_pkg.sv
package dls_pkg;
  typedef enum logic [1:0] {
    ST_LOAD,
    ST_SETUP,
    ST_STROBE,
    ST_RELEASE
  } wr_state_e;

  localparam logic [7:0] ASCII_NL   = 8'h0A;
  localparam logic [7:0] ASCII_ZERO = 8'h30;

  function automatic logic [7:0] bcd_to_ascii(input logic [3:0] d);
    return ASCII_ZERO | {4'h0, d};
  endfunction
endpackage

// File: rtl/dls_bcd_digit.sv
module dls_bcd_digit (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       cin,
  output logic [3:0] q
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      q <= 4'd0;
    end else if (cin) begin
      q <= (q == 4'd9) ? 4'd0 : q + 4'd1;
    end
  end
endmodule

// File: rtl/dls_bcd_counter.sv
module dls_bcd_counter #(
  parameter int DIGITS = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr,
  input  logic                inc,
  output logic [DIGITS*4-1:0] bcd
);
  logic [DIGITS-1:0] carry;

  assign carry[0] = inc;

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    dls_bcd_digit u_digit (
      .clk (clk),
      .rst (rst),
      .clr (clr),
      .cin (carry[g]),
      .q   (bcd[g*4 +: 4])
    );
    if (g < DIGITS - 1) begin : g_carry
      assign carry[g+1] = carry[g] & (bcd[g*4 +: 4] == 4'd9);
    end
  end
endmodule

// File: rtl/dls_line_framer.sv
module dls_line_framer
  import dls_pkg::*;
#(
  parameter int DIGITS = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                room_n,
  input  logic [DIGITS*4-1:0] bcd,
  output logic                wr_stb,
  output logic [7:0]          fifo_data,
  output logic                step
);
  localparam int HOLD_W = DIGITS * 4;
  localparam int IDX_W  = $clog2(DIGITS + 1);
  localparam logic [IDX_W-1:0] IDX_NL   = IDX_W'(DIGITS);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DIGITS - 1);

  wr_state_e         state;
  logic [HOLD_W-1:0] hold;
  logic [IDX_W-1:0]  idx;

  assign step = (state == ST_RELEASE) && (idx == IDX_NL);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_LOAD;
      wr_stb    <= 1'b0;
      fifo_data <= 8'h00;
      hold      <= '0;
      idx       <= '0;
    end else begin
      case (state)
        ST_LOAD: begin
          hold      <= bcd;
          fifo_data <= bcd_to_ascii(bcd[HOLD_W-1 -: 4]);
          idx       <= '0;
          state     <= ST_SETUP;
        end
        ST_SETUP: begin
          if (!room_n) begin
            wr_stb <= 1'b1;
            state  <= ST_STROBE;
          end
        end
        ST_STROBE: begin
          wr_stb <= 1'b0;
          state  <= ST_RELEASE;
        end
        default: begin
          if (idx == IDX_NL) begin
            state <= ST_LOAD;
          end else begin
            idx       <= idx + 1'b1;
            hold      <= {hold[HOLD_W-5:0], 4'h0};
            fifo_data <= (idx == IDX_LAST) ? ASCII_NL
                                           : bcd_to_ascii(hold[HOLD_W-5 -: 4]);
            state     <= ST_SETUP;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/dec_line_streamer.sv
module dec_line_streamer #(
  parameter int CNT_W  = 32,
  parameter int DIGITS = 10,
  parameter int LED_W  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             room_n,
  output logic             wr_stb,
  output logic             rd_stb_n,
  output logic [7:0]       fifo_data,
  output logic [LED_W-1:0] leds
);
  logic [CNT_W-1:0]    count;
  logic [DIGITS*4-1:0] bcd;
  logic                step;
  logic                at_max;

  assign at_max = &count;

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (step) begin
      count <= count + 1'b1;
    end
  end

  dls_bcd_counter #(.DIGITS(DIGITS)) u_bcd (
    .clk (clk),
    .rst (rst),
    .clr (step & at_max),
    .inc (step & ~at_max),
    .bcd (bcd)
  );

  dls_line_framer #(.DIGITS(DIGITS)) u_framer (
    .clk       (clk),
    .rst       (rst),
    .room_n    (room_n),
    .bcd       (bcd),
    .wr_stb    (wr_stb),
    .fifo_data (fifo_data),
    .step      (step)
  );

  assign leds     = count[CNT_W-1 -: LED_W];
  assign rd_stb_n = 1'b1;
endmodule

// File: rtl/dls_checker.sv
module dls_checker #(
  parameter int LED_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             room_n,
  input logic             wr_stb,
  input logic [7:0]       fifo_data,
  input logic [LED_W-1:0] leds
);
  AST_WRITE_NEEDS_ROOM: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_stb) |-> !$past(room_n)); // R4

  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> !wr_stb); // R5

  AST_DATA_HELD: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> $stable(fifo_data)); // R5

  AST_BYTE_IS_TEXT: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> (fifo_data == 8'h0A || (fifo_data >= 8'h30 && fifo_data <= 8'h39))); // R2

  AST_LED_AFTER_LINE: assert property (@(posedge clk) disable iff (rst)
    !$stable(leds) |-> $past(wr_stb, 2)); // R7
endmodule

bind dec_line_streamer dls_checker #(.LED_W(LED_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .room_n    (room_n),
  .wr_stb    (wr_stb),
  .fifo_data (fifo_data),
  .leds      (leds)
);

// File: tb/tb_dec_line_streamer.sv
module line_monitor #(
  parameter int CNT_W  = 32,
  parameter int DIGITS = 10,
  parameter int LED_W  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             room_n,
  input  logic             wr,
  input  logic             rd_n,
  input  logic [7:0]       data,
  input  logic [LED_W-1:0] leds,
  output int               checks,
  output int               errs,
  output int               lines
);
  function automatic logic [7:0] exp_byte(input longint ln, input int pos);
    longint v, dv;
    if (pos == DIGITS) return 8'h0A;
    v  = ln % (longint'(1) << CNT_W);
    dv = 1;
    for (int k = 0; k < DIGITS - 1 - pos; k++) dv = dv * 10;
    return 8'h30 + 8'((v / dv) % 10);
  endfunction

  logic       prev_wr, prev_room, led_due;
  logic [7:0] held;
  int         pos;
  string      tag;
  longint     v, exp_led;

  initial begin
    checks = 0; errs = 0; lines = 0; pos = 0;
    prev_wr = 1'b0; prev_room = 1'b1; led_due = 1'b0; held = 8'h00;
    forever begin
      @(negedge clk);
      if (rst) begin
        prev_wr = 1'b0; prev_room = 1'b1;
      end else begin
        if (led_due) begin
          led_due = 1'b0;
          exp_led = (longint'(lines) % (longint'(1) << CNT_W)) >> (CNT_W - LED_W);
          checks++;
          if (leds !== LED_W'(exp_led)) begin
            errs++;
            $display("FAIL R7 leds after line %0d: got %0h expected %0h", lines, leds, exp_led);
          end
          checks++;
          if (rd_n !== 1'b1) begin
            errs++;
            $display("FAIL R6 read strobe: got %b expected 1", rd_n);
          end
        end
        if (wr && !prev_wr) begin
          held = data;
          checks++;
          if (prev_room !== 1'b0) begin
            errs++;
            $display("FAIL R4 strobe rose without room: got room_n %b expected 0", prev_room);
          end
        end
        if (wr && prev_wr) begin
          checks++; errs++;
          $display("FAIL R5 strobe high two cycles: got 1 expected 0");
        end
        if (!wr && prev_wr) begin
          v = longint'(lines) % (longint'(1) << CNT_W);
          if (pos == DIGITS) tag = "R2";
          else if (lines > 0 && v == 0) tag = "R8";
          else if (v > 0 && v % 10 == 0) tag = "R9";
          else tag = "R3";
          checks++;
          if (data !== exp_byte(longint'(lines), pos)) begin
            errs++;
            $display("FAIL %s line %0d byte %0d: got %0h expected %0h",
                     tag, lines, pos, data, exp_byte(longint'(lines), pos));
          end
          checks++;
          if (data !== held) begin
            errs++;
            $display("FAIL R5 data moved during strobe: got %0h expected %0h", data, held);
          end
          pos++;
          if (pos == DIGITS + 1) begin
            pos = 0;
            lines++;
            led_due = 1'b1;
          end
        end
        prev_wr   = wr;
        prev_room = room_n;
      end
    end
  end
endmodule

module tb_dec_line_streamer;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic room_a = 1'b1, room_b = 1'b1;
  logic wr_a, rd_a, wr_b, rd_b;
  logic [7:0] data_a, data_b, leds_a, leds_b;
  int   chk_a, err_a, lines_a, chk_b, err_b, lines_b;
  int   checks = 0, errors = 0, cycles = 0;
  logic [15:0] lf = 16'hACE1;

  always #5 clk = ~clk;

  dec_line_streamer dut (
    .clk(clk), .rst(rst), .room_n(room_a), .wr_stb(wr_a),
    .rd_stb_n(rd_a), .fifo_data(data_a), .leds(leds_a));

  dec_line_streamer #(.CNT_W(8), .DIGITS(3), .LED_W(8)) dut_w8 (
    .clk(clk), .rst(rst), .room_n(room_b), .wr_stb(wr_b),
    .rd_stb_n(rd_b), .fifo_data(data_b), .leds(leds_b));

  line_monitor #(.CNT_W(32), .DIGITS(10), .LED_W(8)) mon_a (
    .clk(clk), .rst(rst), .room_n(room_a), .wr(wr_a), .rd_n(rd_a),
    .data(data_a), .leds(leds_a), .checks(chk_a), .errs(err_a), .lines(lines_a));

  line_monitor #(.CNT_W(8), .DIGITS(3), .LED_W(8)) mon_b (
    .clk(clk), .rst(rst), .room_n(room_b), .wr(wr_b), .rd_n(rd_b),
    .data(data_b), .leds(leds_b), .checks(chk_b), .errs(err_b), .lines(lines_b));

  // room_n pattern: full speed first, then pseudo-random stalls (R4)
  initial begin
    forever begin
      @(posedge clk);
      #2;
      lf     = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      room_a = (lines_a < 20) ? 1'b0 : (lf[0] & lf[3]);
      room_b = lf[5] | (lf[9] & lf[2]);
    end
  end

  task automatic check_reset(input string when);
    checks++;
    if (wr_a !== 1'b0 || wr_b !== 1'b0) begin
      errors++;
      $display("FAIL R1 %s write strobe: got %b%b expected 00", when, wr_a, wr_b);
    end
    checks++;
    if (rd_a !== 1'b1 || rd_b !== 1'b1) begin
      errors++;
      $display("FAIL R1 %s read strobe: got %b%b expected 11", when, rd_a, rd_b);
    end
    checks++;
    if (leds_a !== 8'h00 || leds_b !== 8'h00) begin
      errors++;
      $display("FAIL R1 %s leds: got %0h/%0h expected 0/0", when, leds_a, leds_b);
    end
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    check_reset("in reset");
    @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check_reset("after reset");
    while ((lines_a < 105 || lines_b < 262) && cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    @(negedge clk);
    if (cycles >= 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got lines %0d/%0d expected 105/262", lines_a, lines_b);
    end
    checks = checks + chk_a + chk_b;
    errors = errors + err_a + err_b;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule